// File: doc/BRIEF.md
# Shadow-RAM Nonvolatile Memory Controller

This block fronts a 256-byte address space in which every host access lands in a volatile working copy (the shadow bank), while a second, persistent bank holds the committed image. The host side is a byte-wide read/write port. Two commands move data between the banks. A commit (copy) command writes the working copy into the persistent bank, but only after an external programming strobe arrives. A reload (recall) command overwrites the working copy from the persistent bank, so that committed data can be verified by reading it back.

Thirty bytes are implemented: an 8-byte challenge area at 00h–07h, a 20-byte response area at 08h–1Bh and a 2-byte configuration word at 1Ch–1Dh, all readable and writable. Everything from 1Eh to FFh is reserved. The persistent bank is a register array inside the block that is not cleared by reset. Each reset ends with an automatic reload, so the working copy always starts from the committed image.

Top module: `nvshadow_ctrl`

## Requirements
- R1: With `busy` low, `host_wr` at an address in 00h–1Dh stores `host_wdata` in the shadow byte at that address. `host_rd` at such an address puts that shadow byte on `host_rdata` one clock later, and `host_rdata` keeps its value until the next accepted read.
- R2: A read of any address in 1Eh–FFh returns FFh one clock later. A write to such an address changes no readable byte.
- R3: Host writes never reach the persistent bank. After host writes with no commit, a reload brings back the previously committed bytes.
- R4: A `copy_req` sampled while `busy` is low raises `busy` on the next clock. No byte is committed until `prog_pulse` is sampled high in a later cycle. A `prog_pulse` sampled while no commit is waiting has no effect.
- R5: Once the strobe is sampled, the commit writes the 30 implemented bytes in order, one byte per clock. `busy` stays high for exactly 30 cycles after the strobe edge.
- R6: A `recall_req` sampled while `busy` is low copies all 30 persistent bytes into the shadow bank. `busy` is high for exactly 30 cycles, starting at the next clock.
- R7: While `busy` is high, `host_rd`, `host_wr`, `copy_req` and `recall_req` are ignored. `host_rdata` holds its value, the shadow bank is unchanged by the host, and no new transfer follows the current one.
- R8: While `rst_n` is low, `busy` is high and `host_rdata` is FFh. After release, an automatic reload keeps `busy` high for 30 cycles. The persistent bank keeps its contents through reset, so a commit that is still waiting for its strobe when reset arrives is abandoned.
- R9: `done` is high for exactly one clock, in the cycle where `busy` first reads low at the end of each commit or reload. `done` is low at all other times.
- R10: When `copy_req` and `recall_req` are sampled together while idle, the commit is taken and the reload is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| host_rd | input | 1 | Read strobe for `host_addr` |
| host_wr | input | 1 | Write strobe for `host_addr` / `host_wdata` |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| copy_req | input | 1 | Commit shadow bank to persistent bank |
| recall_req | input | 1 | Reload shadow bank from persistent bank |
| prog_pulse | input | 1 | Programming strobe that releases a waiting commit |
| busy | output | 1 | A transfer is waiting or running |
| done | output | 1 | One-clock end-of-transfer marker |

## Verification
The hardest state to reach from the ports is a commit that has been accepted but is still waiting for its strobe when reset hits. The only sign that it was dropped is that a later reload shows the old image and not the shadow data that was pending. The bench first commits one known image and then writes a different one into the shadow bank. It then issues the commit, withholds the strobe and applies reset. Finally it reads all 30 bytes after the automatic reload. A related sequence issues a reload and, while it runs, presents host writes, reads and a second command, then checks that none of them left a trace.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
// Package nvs_pkg
// Shared types for the shadow-RAM controller: the sequencer state encoding.
package nvs_pkg;

    // Sequencer states: idle, reloading shadow, commit waiting for strobe, committing.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RELOAD = 2'd1,
        ST_ARMED  = 2'd2,
        ST_COMMIT = 2'd3
    } nvs_state_e;

endpackage

// File: rtl/nvs_byte_bank.sv
`timescale 1ns/1ps
// Module nvs_byte_bank
// A bank of DEPTH byte registers with one write port and one asynchronous
// read port. Indices past DEPTH-1 read as all ones. The bank has no reset,
// so contents survive a reset of the surrounding logic.
// Assumes: the caller never needs two reads in the same cycle.
module nvs_byte_bank #(
    parameter int unsigned DEPTH = 30,
    parameter int unsigned DW    = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] cell_q;

        // Store the byte when this cell is the write target.
        always_ff @(posedge clk) begin
            if (we && wr_idx == IDX_W'(g)) begin
                cell_q <= wr_data;
            end
        end

        assign cells[g] = cell_q;
    end

    // Select the addressed cell; out-of-range indices read as all ones.
    always_comb begin
        if (rd_idx <= LAST) begin
            rd_data = cells[rd_idx];
        end else begin
            rd_data = '1;
        end
    end

endmodule

// File: rtl/nvs_sequencer.sv
`timescale 1ns/1ps
// Module nvs_sequencer
// Runs the commit and reload transfers. It reloads at reset, accepts one
// command while idle (commit wins over reload), holds a commit until the
// programming strobe, then steps a byte index across all DEPTH bytes, one per
// clock. It flags the end of each transfer with a one-clock done pulse.
// Assumes: synchronous active-low reset.
module nvs_sequencer #(
    parameter int unsigned DEPTH = 30,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             copy_req,
    input  logic             recall_req,
    input  logic             prog_pulse,
    output logic             busy,
    output logic             done,
    output logic             shadow_load,
    output logic             nv_we,
    output logic [IDX_W-1:0] xfer_idx
);

    import nvs_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    nvs_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;

    // State, byte index and done marker update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RELOAD;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (copy_req) begin
                        state_q <= ST_ARMED;
                    end else if (recall_req) begin
                        state_q <= ST_RELOAD;
                        idx_q   <= '0;
                    end
                end
                ST_ARMED: begin
                    if (prog_pulse) begin
                        state_q <= ST_COMMIT;
                        idx_q   <= '0;
                    end
                end
                ST_RELOAD, ST_COMMIT: begin
                    if (idx_q == LAST) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the state into transfer controls.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        shadow_load = (state_q == ST_RELOAD);
        nv_we       = (state_q == ST_COMMIT);
        xfer_idx    = idx_q;
        done        = done_q;
    end

endmodule

// File: rtl/nvs_host_port.sv
`timescale 1ns/1ps
// Module nvs_host_port
// Host-side byte port. It decodes addresses into the implemented range,
// gates access while a transfer is busy, and registers read data. Reserved
// addresses read as all ones and their writes are dropped.
// Assumes: IMPL_BYTES <= 2**ADDR_W and the shadow bank read is combinational.
module nvs_host_port #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DW         = 8,
    parameter int unsigned IMPL_BYTES = 30,
    localparam int unsigned IDX_W = $clog2(IMPL_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     bank_rdata,
    output logic [IDX_W-1:0]  bank_idx,
    output logic              bank_we,
    output logic [DW-1:0]     host_rdata
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(IMPL_BYTES - 1);

    logic          in_range;
    logic [DW-1:0] rdata_q;

    // Address decode and write gating.
    always_comb begin
        in_range = (host_addr <= TOP_ADDR);
        bank_idx = host_addr[IDX_W-1:0];
        bank_we  = host_wr && !busy && in_range;
    end

    // Capture read data on an accepted read; reserved addresses give all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '1;
        end else if (host_rd && !busy) begin
            rdata_q <= in_range ? bank_rdata : '1;
        end
    end

    assign host_rdata = rdata_q;

endmodule

// File: rtl/nvshadow_ctrl.sv
`timescale 1ns/1ps
// Module nvshadow_ctrl
// Top of the shadow-RAM controller. It joins the host port, the shadow bank,
// the persistent bank and the transfer sequencer. The host reaches only the
// shadow bank. Commit and reload move whole images between the banks.
// Assumes: synchronous active-low reset; the persistent bank is never reset.
module nvshadow_ctrl #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DW         = 8,
    parameter int unsigned IMPL_BYTES = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic              copy_req,
    input  logic              recall_req,
    input  logic              prog_pulse,
    output logic              busy,
    output logic              done
);

    localparam int unsigned IDX_W = $clog2(IMPL_BYTES);

    logic             shadow_load;
    logic             nv_we;
    logic [IDX_W-1:0] xfer_idx;
    logic [IDX_W-1:0] host_idx;
    logic             host_we;
    logic             sh_we;
    logic [IDX_W-1:0] sh_wr_idx;
    logic [DW-1:0]    sh_wr_data;
    logic [IDX_W-1:0] sh_rd_idx;
    logic [DW-1:0]    sh_rd_data;
    logic [DW-1:0]    nv_rd_data;

    nvs_sequencer #(.DEPTH(IMPL_BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .copy_req    (copy_req),
        .recall_req  (recall_req),
        .prog_pulse  (prog_pulse),
        .busy        (busy),
        .done        (done),
        .shadow_load (shadow_load),
        .nv_we       (nv_we),
        .xfer_idx    (xfer_idx)
    );

    nvs_host_port #(.ADDR_W(ADDR_W), .DW(DW), .IMPL_BYTES(IMPL_BYTES)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .bank_rdata (sh_rd_data),
        .bank_idx   (host_idx),
        .bank_we    (host_we),
        .host_rdata (host_rdata)
    );

    // Shadow bank port sharing: a reload owns the write port, the host owns the rest.
    always_comb begin
        sh_we      = shadow_load || host_we;
        sh_wr_idx  = shadow_load ? xfer_idx : host_idx;
        sh_wr_data = shadow_load ? nv_rd_data : host_wdata;
        sh_rd_idx  = busy ? xfer_idx : host_idx;
    end

    nvs_byte_bank #(.DEPTH(IMPL_BYTES), .DW(DW)) u_shadow (
        .clk     (clk),
        .we      (sh_we),
        .wr_idx  (sh_wr_idx),
        .wr_data (sh_wr_data),
        .rd_idx  (sh_rd_idx),
        .rd_data (sh_rd_data)
    );

    nvs_byte_bank #(.DEPTH(IMPL_BYTES), .DW(DW)) u_nv (
        .clk     (clk),
        .we      (nv_we),
        .wr_idx  (xfer_idx),
        .wr_data (sh_rd_data),
        .rd_idx  (xfer_idx),
        .rd_data (nv_rd_data)
    );

endmodule

// File: rtl/nvs_ctrl_chk.sv
`timescale 1ns/1ps
// Module nvs_ctrl_chk
// Protocol checker for nvshadow_ctrl, attached by bind. It watches the ports
// and the persistent-bank write enable.
module nvs_ctrl_chk #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DW         = 8,
    parameter int unsigned IMPL_BYTES = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DW-1:0]     host_rdata,
    input logic              copy_req,
    input logic              prog_pulse,
    input logic              busy,
    input logic              done,
    input logic              nv_we
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(IMPL_BYTES - 1);

    assert_reserved_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !busy && host_addr > TOP_ADDR) |=> (host_rdata == '1));

    assert_nv_only_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> busy);

    assert_copy_takes_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req && !busy) |=> busy);

    assert_commit_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_we) |-> $past(prog_pulse));

    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(host_rdata));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind nvshadow_ctrl nvs_ctrl_chk #(
    .ADDR_W(ADDR_W), .DW(DW), .IMPL_BYTES(IMPL_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .copy_req   (copy_req),
    .prog_pulse (prog_pulse),
    .busy       (busy),
    .done       (done),
    .nv_we      (nv_we)
);

// File: tb/tb_nvshadow_ctrl.sv
`timescale 1ns/1ps
module tb_nvshadow_ctrl;

    localparam int N = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       copy_req = 1'b0;
    logic       recall_req = 1'b0;
    logic       prog_pulse = 1'b0;
    logic       busy;
    logic       done;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] nv_model [N];
    logic [7:0] sh_model [N];

    always #4 clk = ~clk;

    nvshadow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .copy_req(copy_req), .recall_req(recall_req), .prog_pulse(prog_pulse),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 13) ^ (i << 3));
    endfunction

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    // Count negedges with busy high; report done at the first idle negedge.
    task automatic busy_span(output int n, output logic d);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        d = done;
    endtask

    task automatic fill_shadow(input int seed);
        for (int i = 0; i < N; i++) begin
            host_write(8'(i), pat(seed, i));
            sh_model[i] = pat(seed, i);
        end
    endtask

    task automatic verify_shadow(input string req);
        logic [7:0] d;
        for (int i = 0; i < N; i++) begin
            host_read(8'(i), d);
            check(d === sh_model[i], req, d, sh_model[i]);
        end
    endtask

    task automatic commit_with_strobe;
        int n; logic d;
        copy_req = 1'b1; @(negedge clk); copy_req = 1'b0;
        prog_pulse = 1'b1; @(negedge clk); prog_pulse = 1'b0;
        busy_span(n, d);
        check(n == 30, "R5 commit busy cycles", n, 30);
        check(d === 1'b1, "R9 done at commit end", d, 1);
        @(negedge clk);
        check(done === 1'b0, "R9 done one clock", done, 0);
        for (int i = 0; i < N; i++) nv_model[i] = sh_model[i];
    endtask

    task automatic test_reset;
        int n; logic d; logic [7:0] r;
        repeat (3) @(negedge clk);
        check(busy === 1'b1, "R8 busy in reset", busy, 1);
        check(host_rdata === 8'hFF, "R8 rdata in reset", host_rdata, 8'hFF);
        rst_n = 1'b1;
        busy_span(n, d);
        check(n == 30, "R8 auto reload cycles", n, 30);
        check(d === 1'b1, "R9 done after auto reload", d, 1);
        @(negedge clk);
        check(done === 1'b0, "R9 done drops", done, 0);
        host_read(8'h1E, r);
        check(r === 8'hFF, "R2 reserved after reset", r, 8'hFF);
    endtask

    task automatic test_write_read;
        fill_shadow(1);
        verify_shadow("R1 write/read");
        fill_shadow(2);
        verify_shadow("R1 rewrite/read");
    endtask

    task automatic test_reserved;
        logic [7:0] r;
        host_write(8'h1E, 8'h00);
        host_write(8'h80, 8'h12);
        host_write(8'hFF, 8'h34);
        host_read(8'h1E, r); check(r === 8'hFF, "R2 read 1Eh", r, 8'hFF);
        host_read(8'hFF, r); check(r === 8'hFF, "R2 read FFh", r, 8'hFF);
        verify_shadow("R2 reserved write left bytes intact");
    endtask

    task automatic test_commit;
        prog_pulse = 1'b1; @(negedge clk); prog_pulse = 1'b0;
        check(busy === 1'b0, "R4 stray strobe ignored", busy, 0);
        check(done === 1'b0, "R4 stray strobe no done", done, 0);
        copy_req = 1'b1; @(negedge clk); copy_req = 1'b0;
        check(busy === 1'b1, "R4 busy after copy_req", busy, 1);
        repeat (6) @(negedge clk);
        check(busy === 1'b1 && done === 1'b0, "R4 waits for strobe", {busy, done}, 2'b10);
        prog_pulse = 1'b1; @(negedge clk); prog_pulse = 1'b0;
        begin
            int n; logic d;
            busy_span(n, d);
            check(n == 30, "R5 commit busy cycles", n, 30);
            check(d === 1'b1, "R9 done at commit end", d, 1);
        end
        for (int i = 0; i < N; i++) nv_model[i] = sh_model[i];
    endtask

    task automatic test_shadow_only;
        int n; logic d;
        fill_shadow(3);
        verify_shadow("R3 shadow holds new data");
        recall_req = 1'b1; @(negedge clk); recall_req = 1'b0;
        busy_span(n, d);
        check(n == 30, "R6 reload busy cycles", n, 30);
        check(d === 1'b1, "R9 done at reload end", d, 1);
        for (int i = 0; i < N; i++) sh_model[i] = nv_model[i];
        verify_shadow("R3 R6 reload restores committed image");
    endtask

    task automatic test_busy_ignore;
        logic [7:0] r0; int n; logic d;
        host_read(8'h00, r0);
        recall_req = 1'b1; @(negedge clk); recall_req = 1'b0;
        host_write(8'h03, ~nv_model[3]);
        host_rd = 1'b1; host_addr = 8'h05; @(negedge clk); host_rd = 1'b0;
        check(host_rdata === r0, "R7 read ignored while busy", host_rdata, r0);
        copy_req = 1'b1; recall_req = 1'b1; @(negedge clk);
        copy_req = 1'b0; recall_req = 1'b0;
        busy_span(n, d);
        check(d === 1'b1, "R9 done after reload", d, 1);
        @(negedge clk);
        check(busy === 1'b0, "R7 command during busy dropped", busy, 0);
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R7 still idle", busy, 0);
        verify_shadow("R7 write ignored while busy");
    endtask

    task automatic test_priority;
        int n; logic d;
        fill_shadow(4);
        copy_req = 1'b1; recall_req = 1'b1; @(negedge clk);
        copy_req = 1'b0; recall_req = 1'b0;
        repeat (40) @(negedge clk);
        check(busy === 1'b1 && done === 1'b0, "R10 commit chosen, waits", {busy, done}, 2'b10);
        prog_pulse = 1'b1; @(negedge clk); prog_pulse = 1'b0;
        busy_span(n, d);
        check(n == 30, "R10 commit ran", n, 30);
        for (int i = 0; i < N; i++) nv_model[i] = sh_model[i];
        fill_shadow(5);
        recall_req = 1'b1; @(negedge clk); recall_req = 1'b0;
        busy_span(n, d);
        for (int i = 0; i < N; i++) sh_model[i] = nv_model[i];
        verify_shadow("R10 committed image after priority");
    endtask

    task automatic test_reset_abort;
        int n; logic d;
        fill_shadow(6);
        copy_req = 1'b1; @(negedge clk); copy_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0; repeat (2) @(negedge clk);
        rst_n = 1'b1;
        busy_span(n, d);
        check(n == 30, "R8 reload after reset", n, 30);
        for (int i = 0; i < N; i++) sh_model[i] = nv_model[i];
        verify_shadow("R8 pending commit abandoned, bank kept");
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset;
        test_write_read;
        fill_shadow(7);
        commit_with_strobe;
        test_reserved;
        test_commit;
        test_shadow_only;
        test_busy_ignore;
        test_priority;
        test_reset_abort;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule